// File: doc/BRIEF.md
# Completion Ring Writer with Phase Tag

This block sits on the device side of a storage controller and turns finished commands into entries of circular completion rings held in host memory. Each request names the target ring, the submission queue it came from, the submission-queue head to report, the command identifier and a 15-bit status. The block builds a 16-byte entry from these and issues one memory write at the ring base plus sixteen times the ring's tail index. It then advances the tail. Every entry carries a phase bit, and that bit changes value each time the ring wraps. A host that polls the ring can therefore tell new entries from stale ones without reading any pointer.

The host reports how far it has consumed each ring by writing a head value through a doorbell port. The block refuses a request whose ring has no free slot and holds it with backpressure until a doorbell frees a slot. After each entry write is accepted downstream, the block can raise a one-cycle interrupt strobe, enabled separately for each ring. Ring sizes and bases come in as static configuration. Dropping the controller enable returns every ring to its initial state.

Top module: `cqp_poster`

## Requirements
- R1: An entry is 128 bits. Bits 63:0 are zero. Bits 79:64 hold the reported SQ head and bits 95:80 the SQ identifier. Bits 111:96 hold the command identifier, bit 112 the phase and bits 127:113 the status (status code in status bits 7:0, status code type in status bits 10:8).
- R2: The write address is the ring base plus 16 times the tail index the ring had when the request was accepted.
- R3: A request is not accepted (`req_ready` low) while, for its ring, the tail plus one modulo the ring size equals the head. An entry never lands on a slot the host has not consumed.
- R4: Each accepted entry advances its ring's tail by one. After index `last` (ring size minus one) the tail returns to 0.
- R5: The phase written is 1 on the first pass around a ring. It inverts each time that ring's tail wraps from `last` to 0.
- R6: A head doorbell replaces the stored head of the selected ring from the next cycle on. A ring that was full accepts again once the new head frees a slot.
- R7: Only one entry is in flight at a time. While `wr_valid` is high and `wr_ready` is low, the address and data stay unchanged and `req_ready` stays low.
- R8: In the cycle after a write handshake (`wr_valid` and `wr_ready` both high), `irq_pulse` is high for exactly one cycle, with `irq_qid` naming the ring, if that ring's bit in `cq_int_en` is set. Otherwise no pulse occurs.
- R9: While reset is asserted, or at an edge where `ctrl_en` is low, every ring returns to tail 0, head 0 and phase 1. Any pending write is dropped and `req_ready` is low.
- R10: Rings are independent: the tail, phase and head of one ring change only through requests and doorbells that address it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_en | input | 1 | Controller enable; low resets all rings |
| cq_base | input | NUM_CQ*ADDR_W | Byte base address of each ring, ring 0 in the low slice |
| cq_last | input | NUM_CQ*PTR_W | Highest slot index (size minus one) of each ring |
| cq_int_en | input | NUM_CQ | Interrupt enable per ring |
| req_valid | input | 1 | Completion request present |
| req_ready | output | 1 | Request accepted this cycle when high with `req_valid` |
| req_cqid | input | QID_W | Target ring |
| req_sqid | input | 16 | Submission queue identifier to report |
| req_sqhd | input | 16 | Submission queue head to report |
| req_cid | input | 16 | Command identifier |
| req_status | input | 15 | Status field |
| hdb_valid | input | 1 | Head doorbell write |
| hdb_qid | input | QID_W | Ring addressed by the doorbell |
| hdb_head | input | PTR_W | New head index |
| wr_valid | output | 1 | Entry write pending |
| wr_ready | input | 1 | Memory side accepts the write |
| wr_addr | output | ADDR_W | Byte address of the entry |
| wr_data | output | 128 | Entry contents |
| irq_pulse | output | 1 | One-cycle interrupt strobe |
| irq_qid | output | QID_W | Ring that raised the strobe |

## Verification
The assertions assume that `cq_last` is at least 1 and stays constant while `ctrl_en` is high. They also assume that every `req_cqid` and `hdb_qid` names an existing ring, and that a doorbell head only moves forward around the ring without passing the tail. The stimulus meets these assumptions: ring sizes are fixed before enable, and doorbell values are derived from the bench's own model of each ring, moving a head one slot toward its tail or directly onto it. Request fields, ring selection, `wr_ready` and doorbell timing are otherwise free, so rings fill, wrap, stall and interleave in arbitrary order.

// File: rtl/cqp_pkg.sv
`timescale 1ns/1ps
package cqp_pkg;

  localparam int ENTRY_BYTES = 16;
  localparam int ENTRY_W     = ENTRY_BYTES * 8;
  localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);
  localparam int STATUS_W    = 15;

  typedef struct packed {
    logic [15:0]         sqid;
    logic [15:0]         sqhd;
    logic [15:0]         cid;
    logic [STATUS_W-1:0] status;
  } cpl_req_t;

  // Entry image: dword3 = status|phase|cid, dword2 = sqid|sqhd, dword1/0 zero
  function automatic logic [ENTRY_W-1:0] pack_entry(input cpl_req_t r, input logic phase);
    return {r.status, phase, r.cid, r.sqid, r.sqhd, 64'd0};
  endfunction

endpackage

// File: rtl/cqp_ring_ctx.sv
`timescale 1ns/1ps
module cqp_ring_ctx #(
  parameter int PTR_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_en,
  input  logic [PTR_W-1:0] last_idx,
  input  logic             take,
  input  logic             hdb_wr,
  input  logic [PTR_W-1:0] hdb_val,
  output logic [PTR_W-1:0] tail,
  output logic             phase,
  output logic             full
);

  logic [PTR_W-1:0] tail_q, head_q, tail_nxt;
  logic             phase_q, at_end;

  function automatic logic [PTR_W-1:0] ring_step(input logic [PTR_W-1:0] p,
                                                 input logic [PTR_W-1:0] lst);
    return (p == lst) ? '0 : p + 1'b1;
  endfunction

  assign at_end   = (tail_q == last_idx);
  assign tail_nxt = ring_step(tail_q, last_idx);
  assign full     = (tail_nxt == head_q);
  assign tail     = tail_q;
  assign phase    = phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !ctrl_en) begin
      tail_q  <= '0;
      head_q  <= '0;
      phase_q <= 1'b1;
    end else begin
      if (take) begin
        tail_q <= tail_nxt;
        if (at_end) phase_q <= ~phase_q;
      end
      if (hdb_wr) head_q <= hdb_val;
    end
  end

  // R3: the slot just filled never becomes the host's head position
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n || !ctrl_en)
    take && !hdb_wr |=> tail_q != head_q);

  assert_tail_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n || !ctrl_en)
    take && at_end |=> tail_q == '0);

  assert_phase_flip_R5: assert property (@(posedge clk) disable iff (!rst_n || !ctrl_en)
    take && at_end |=> phase_q != $past(phase_q));

  assert_phase_hold_R5: assert property (@(posedge clk) disable iff (!rst_n || !ctrl_en)
    !(take && at_end) |=> $stable(phase_q));

  assert_disable_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> tail_q == '0 && head_q == '0 && phase_q);

endmodule

// File: rtl/cqp_out_stage.sv
`timescale 1ns/1ps
module cqp_out_stage
  import cqp_pkg::*;
#(
  parameter int NUM_CQ = 4,
  parameter int ADDR_W = 48,
  parameter int QID_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_en,
  input  logic               load,
  input  logic [ADDR_W-1:0]  load_addr,
  input  logic [ENTRY_W-1:0] load_data,
  input  logic [QID_W-1:0]   load_qid,
  input  logic [NUM_CQ-1:0]  int_en,
  input  logic               wr_ready,
  output logic               busy,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [ENTRY_W-1:0] wr_data,
  output logic               fire,
  output logic               irq_pulse,
  output logic [QID_W-1:0]   irq_qid
);

  logic [QID_W-1:0] qid_q;

  assign fire = busy && wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      qid_q     <= '0;
      irq_pulse <= 1'b0;
      irq_qid   <= '0;
    end else begin
      irq_pulse <= fire && int_en[qid_q];
      irq_qid   <= qid_q;
      if (!ctrl_en) begin
        busy <= 1'b0;
      end else if (load) begin
        busy    <= 1'b1;
        wr_addr <= load_addr;
        wr_data <= load_data;
        qid_q   <= load_qid;
      end else if (fire) begin
        busy <= 1'b0;
      end
    end
  end

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n || !ctrl_en)
    busy && !wr_ready |=> busy && $stable(wr_addr) && $stable(wr_data));

  assert_irq_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(fire));

  assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

endmodule

// File: rtl/cqp_poster.sv
`timescale 1ns/1ps
module cqp_poster
  import cqp_pkg::*;
#(
  parameter  int NUM_CQ = 4,
  parameter  int PTR_W  = 12,
  parameter  int ADDR_W = 48,
  localparam int QID_W  = (NUM_CQ > 1) ? $clog2(NUM_CQ) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ctrl_en,
  input  logic [NUM_CQ*ADDR_W-1:0] cq_base,
  input  logic [NUM_CQ*PTR_W-1:0]  cq_last,
  input  logic [NUM_CQ-1:0]        cq_int_en,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [QID_W-1:0]         req_cqid,
  input  logic [15:0]              req_sqid,
  input  logic [15:0]              req_sqhd,
  input  logic [15:0]              req_cid,
  input  logic [STATUS_W-1:0]      req_status,
  input  logic                     hdb_valid,
  input  logic [QID_W-1:0]         hdb_qid,
  input  logic [PTR_W-1:0]         hdb_head,
  output logic                     wr_valid,
  input  logic                     wr_ready,
  output logic [ADDR_W-1:0]        wr_addr,
  output logic [ENTRY_W-1:0]       wr_data,
  output logic                     irq_pulse,
  output logic [QID_W-1:0]         irq_qid
);

  logic [PTR_W-1:0]  tail_v [NUM_CQ];
  logic [NUM_CQ-1:0] phase_v, full_v, take_v, hdb_v;
  logic              busy, fire, accept;
  logic [ADDR_W-1:0] sel_base, slot;
  cpl_req_t          rq;

  function automatic logic [ADDR_W-1:0] slot_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [PTR_W-1:0]  idx);
    return base + (ADDR_W'(idx) << ENTRY_SHIFT);
  endfunction

  generate
    for (genvar g = 0; g < NUM_CQ; g++) begin : g_ring
      assign take_v[g] = accept && (req_cqid == QID_W'(g));
      assign hdb_v[g]  = hdb_valid && (hdb_qid == QID_W'(g));
      cqp_ring_ctx #(.PTR_W(PTR_W)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_en  (ctrl_en),
        .last_idx (cq_last[g*PTR_W +: PTR_W]),
        .take     (take_v[g]),
        .hdb_wr   (hdb_v[g]),
        .hdb_val  (hdb_head),
        .tail     (tail_v[g]),
        .phase    (phase_v[g]),
        .full     (full_v[g])
      );
    end
  endgenerate

  assign req_ready = ctrl_en && !busy && !full_v[req_cqid];
  assign accept    = req_valid && req_ready;
  assign sel_base  = cq_base[req_cqid*ADDR_W +: ADDR_W];
  assign slot      = slot_addr(sel_base, tail_v[req_cqid]);
  assign rq        = '{sqid: req_sqid, sqhd: req_sqhd, cid: req_cid, status: req_status};
  assign wr_valid  = busy;

  cqp_out_stage #(.NUM_CQ(NUM_CQ), .ADDR_W(ADDR_W), .QID_W(QID_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_en   (ctrl_en),
    .load      (accept),
    .load_addr (slot),
    .load_data (pack_entry(rq, phase_v[req_cqid])),
    .load_qid  (req_cqid),
    .int_en    (cq_int_en),
    .wr_ready  (wr_ready),
    .busy      (busy),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .fire      (fire),
    .irq_pulse (irq_pulse),
    .irq_qid   (irq_qid)
  );

  // R7: a pending write keeps new requests out
  assert_one_inflight_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> !(req_valid && req_ready) || !$past(ctrl_en) || !ctrl_en);

endmodule

// File: tb/test_cqp_poster.sv
`timescale 1ns/1ps
module test_cqp_poster;
  localparam int NQ = 4;
  localparam int PW = 12;
  localparam int AW = 48;

  logic              clk = 1'b0;
  logic              rst_n, ctrl_en;
  logic [NQ*AW-1:0]  cq_base;
  logic [NQ*PW-1:0]  cq_last;
  logic [NQ-1:0]     cq_int_en;
  logic              req_valid, req_ready;
  logic [1:0]        req_cqid, hdb_qid, irq_qid;
  logic [15:0]       req_sqid, req_sqhd, req_cid;
  logic [14:0]       req_status;
  logic              hdb_valid, wr_valid, wr_ready, irq_pulse;
  logic [PW-1:0]     hdb_head;
  logic [AW-1:0]     wr_addr;
  logic [127:0]      wr_data;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  string scen = "reset";

  always #10 clk = ~clk;

  cqp_poster #(.NUM_CQ(NQ), .PTR_W(PW), .ADDR_W(AW)) i_cqp_poster (
    .clk, .rst_n, .ctrl_en, .cq_base, .cq_last, .cq_int_en,
    .req_valid, .req_ready, .req_cqid, .req_sqid, .req_sqhd, .req_cid, .req_status,
    .hdb_valid, .hdb_qid, .hdb_head, .wr_valid, .wr_ready, .wr_addr, .wr_data,
    .irq_pulse, .irq_qid
  );

  function automatic int last_of(int q);
    case (q) 0: return 3; 1: return 2; 2: return 7; default: return 1; endcase
  endfunction
  function automatic logic [AW-1:0] base_of(int q);
    return 48'h0000_8000_0000 + AW'(q) * 48'h1_0000;
  endfunction

  // ---------------- behavioural reference model ----------------
  int   m_tail [NQ];
  int   m_head [NQ];
  bit   m_ph   [NQ];
  bit   m_wv, m_irq, m_rdy, m_fire;
  int   m_q, m_irqq, qq;
  logic [AW-1:0]  m_addr;
  logic [127:0]   m_data;

  function automatic bit m_full(int q);
    int nx = (m_tail[q] == last_of(q)) ? 0 : m_tail[q] + 1;
    return nx == m_head[q];
  endfunction

  function automatic bit m_ready();
    return ctrl_en && !m_wv && !m_full(int'(req_cqid));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int q = 0; q < NQ; q++) begin m_tail[q] = 0; m_head[q] = 0; m_ph[q] = 1; end
      m_wv = 0; m_irq = 0; m_q = 0; m_irqq = 0; m_addr = '0; m_data = '0;
    end else begin
      m_rdy  = m_ready();
      m_fire = m_wv && wr_ready;
      m_irq  = m_fire && cq_int_en[m_q];
      m_irqq = m_q;
      if (!ctrl_en) begin
        for (int q = 0; q < NQ; q++) begin m_tail[q] = 0; m_head[q] = 0; m_ph[q] = 1; end
        m_wv = 0;
      end else begin
        if (req_valid && m_rdy) begin
          qq     = int'(req_cqid);
          m_addr = base_of(qq) + AW'(m_tail[qq] * 16);
          m_data = {req_status, m_ph[qq], req_cid, req_sqid, req_sqhd, 64'h0};
          m_wv   = 1;
          m_q    = qq;
          if (m_tail[qq] == last_of(qq)) begin m_tail[qq] = 0; m_ph[qq] = !m_ph[qq]; end
          else m_tail[qq] = m_tail[qq] + 1;
        end else if (m_fire) begin
          m_wv = 0;
        end
        if (hdb_valid) m_head[int'(hdb_qid)] = int'(hdb_head);
      end
    end
  end

  // ---------------- comparison ----------------
  task automatic chk(string req, string what, logic [127:0] got, logic [127:0] exp);
    if (got !== exp) begin
      errors++;
      $display("FAIL %s [%s] %s got %0h expected %0h", req, scen, what, got, exp);
    end
  endtask

  task automatic compare();
    vectors++;
    chk("R3", "req_ready", 128'(req_ready), 128'(m_ready()));
    chk("R7", "wr_valid",  128'(wr_valid),  128'(m_wv));
    if (m_wv) begin
      chk("R2", "wr_addr", 128'(wr_addr), 128'(m_addr));
      chk("R1", "entry fields", {wr_data[127:113], wr_data[111:0]}, {m_data[127:113], m_data[111:0]});
      chk("R5", "phase bit", 128'(wr_data[112]), 128'(m_data[112]));
    end
    chk("R8", "irq_pulse", 128'(irq_pulse), 128'(m_irq));
    if (m_irq) chk("R8", "irq_qid", 128'(irq_qid), 128'(m_irqq));
  endtask

  task automatic tick();
    #1 compare();
    @(negedge clk);
  endtask

  task automatic post(int q, int cid);
    req_valid  = 1'b1;
    req_cqid   = 2'(q);
    req_cid    = 16'(cid);
    req_sqid   = 16'(q + 16'h100);
    req_sqhd   = 16'(cid * 3);
    req_status = 15'(cid * 37);
    tick();
  endtask

  task automatic idle(int n);
    req_valid = 1'b0; hdb_valid = 1'b0;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic ring_bell(int q, int h);
    req_valid = 1'b0;
    hdb_valid = 1'b1; hdb_qid = 2'(q); hdb_head = PW'(h);
    tick();
    hdb_valid = 1'b0;
  endtask

  task automatic random_phase(int n);
    for (int i = 0; i < n; i++) begin
      int q;
      req_valid  = ($urandom % 3) != 0;
      req_cqid   = 2'($urandom % NQ);
      req_cid    = 16'($urandom);
      req_sqid   = 16'($urandom);
      req_sqhd   = 16'($urandom);
      req_status = 15'($urandom);
      wr_ready   = ($urandom % 4) != 0;
      q          = int'($urandom % NQ);
      hdb_valid  = (($urandom % 3) == 0) && (m_head[q] != m_tail[q]);
      hdb_qid    = 2'(q);
      if ($urandom % 2 == 0) hdb_head = PW'(m_tail[q]);
      else hdb_head = PW'((m_head[q] == last_of(q)) ? 0 : m_head[q] + 1);
      tick();
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  initial begin
    for (int q = 0; q < NQ; q++) begin
      cq_base[q*AW +: AW] = base_of(q);
      cq_last[q*PW +: PW] = PW'(last_of(q));
    end
    rst_n = 1'b0; ctrl_en = 1'b0; cq_int_en = '0;
    req_valid = 1'b0; req_cqid = '0; req_sqid = '0; req_sqhd = '0; req_cid = '0; req_status = '0;
    hdb_valid = 1'b0; hdb_qid = '0; hdb_head = '0; wr_ready = 1'b1;
    @(negedge clk);
    scen = "R9 reset state";
    idle(3);
    rst_n = 1'b1; ctrl_en = 1'b1;
    idle(1);

    scen = "R3 fill ring 0";       // 4 slots, 3 usable before full
    for (int k = 0; k < 8; k++) post(0, k + 1);
    idle(2);

    scen = "R6 doorbell frees ring 0";
    ring_bell(0, 2);
    scen = "R4 R5 wrap ring 0";
    for (int k = 0; k < 6; k++) post(0, 20 + k);
    idle(2);

    scen = "R7 stall";
    wr_ready = 1'b0;
    post(2, 40);
    for (int k = 0; k < 4; k++) post(2, 41 + k);
    wr_ready = 1'b1;
    idle(2);

    scen = "R8 interrupt enable";
    cq_int_en = 4'b0010;
    post(1, 50); idle(2);
    post(2, 51); idle(2);
    post(1, 52); idle(3);

    scen = "R10 cross-ring";       // ring 3 fills after one entry, ring 2 keeps going
    for (int k = 0; k < 4; k++) begin post(3, 60 + k); post(2, 70 + k); end
    idle(2);

    scen = "random traffic";
    cq_int_en = 4'b1011;
    random_phase(3000);
    wr_ready = 1'b1;
    idle(3);

    scen = "R9 controller disable";
    ctrl_en = 1'b0;
    idle(2);
    post(0, 90);
    ctrl_en = 1'b1;
    post(0, 91); idle(2);
    post(3, 92); idle(2);

    scen = "random after re-enable";
    random_phase(1500);
    wr_ready = 1'b1;
    idle(4);
    finish_run();
  end
endmodule